// File: doc/BRIEF.md
# Centred Window Finger Counter

This block sits at the end of a binary image pipeline. It takes the video timing of an active-high scan (horizontal sync, vertical sync, data enable) and one bit per pixel from the edge stage, where 0 marks an edge pixel. It tracks the column and active-row position of every pixel. From these it marks a square region of interest placed in the middle of the active frame. Inside that region it turns the binary pixel into black or white RGB for a monitor. Outside the region, active pixels are shown as a flat grey.

On the single scan line at the vertical middle of the region, the block counts the edge pixels that fall inside the region's columns. Every raised finger crosses that line with two edges, so half that count is the number of fingers. When the next frame sync begins, the block turns the count into a one-byte gesture code for a serial transmitter that runs 8N1 at 4800 baud. It flags that code with a one-cycle strobe.

Top module: `fcw_window_counter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `rgb_o` is 0, `win_o` is 0, `code_vld_o` is 0 and `code_o` is 0xF0.
- R2: The column index is 0 for the first enabled pixel after each rising edge of `hsync_i`, and rises by one for each enabled pixel. The row index counts only lines that carry enabled pixels, so the first such line after a rising edge of `vsync_i` is row 0.
- R3: `win_o` is 1 exactly one cycle after an enabled pixel whose column lies in [X0, X0+WIN) and whose row lies in [Y0, Y0+WIN), where X0=(H_ACT-WIN)/2 and Y0=(V_ACT-WIN)/2. Otherwise it is 0.
- R4: One cycle after an enabled pixel inside the window, `rgb_o` is 24'h000000 if `pix_i` was 0 and 24'hFFFFFF if `pix_i` was 1.
- R5: One cycle after an enabled pixel outside the window, `rgb_o` is 24'h808080. One cycle after any cycle with `de_i` low, `rgb_o` is 0.
- R6: Only pixels with `pix_i`=0 on row Y0+WIN/2 and inside the window columns are counted. Zero pixels on other rows, or on that row outside the window columns, have no effect on the code.
- R7: With B the number of counted pixels and F=floor(B/2), the code is 0xF0+F when 1<=F<=4. Otherwise it is 0xF0, which means no gesture.
- R8: The cycle after a rising edge of `vsync_i` is sampled, `code_o` carries the new code and `code_vld_o` is 1 for exactly that one cycle. `code_o` keeps its value until the next such update.
- R9: The count restarts at each rising edge of `vsync_i`, so a frame with no counted pixels yields 0xF0 whatever came before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| de_i | input | 1 | Active pixel enable |
| pix_i | input | 1 | Binary pixel from the edge stage, 0 = edge |
| rgb_o | output | 24 | Display colour, one cycle behind the input pixel |
| win_o | output | 1 | Pixel one cycle earlier lay inside the window |
| code_o | output | 8 | Latched gesture code |
| code_vld_o | output | 1 | One-cycle strobe marking a new code |

## Verification
A wrong column or row counter moves the window. This shows up at `win_o` and `rgb_o` on the first pixel of the line or frame where the edge lies, one cycle after that pixel enters. A slip in the black tally, or a tally not cleared between frames, only surfaces at the code. The code appears one cycle after the next frame sync, so every frame is checked by comparing the code against a count taken from the bench's own stored pixel pattern. Edge pixels placed on the line just above the centre line, or on the centre line just outside the window, show at once a counter that picks the wrong row or the wrong span.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

    localparam logic [23:0] RGB_BLACK = 24'h000000;
    localparam logic [23:0] RGB_WHITE = 24'hFFFFFF;

    // Turns an edge-pixel tally into a gesture code.
    function automatic logic [7:0] fcw_encode(input int unsigned blacks,
                                              input int unsigned max_f,
                                              input logic [7:0]  base);
        int unsigned fingers;
        fingers = blacks / 2;
        if (fingers >= 1 && fingers <= max_f)
            return base + 8'(fingers);
        return base;
    endfunction

endpackage

// File: rtl/fcw_scan.sv
module fcw_scan #(
    parameter int unsigned H_ACT = 800,
    parameter int unsigned V_ACT = 600,
    parameter int unsigned WIN   = 250
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hsync_i,
    input  logic vsync_i,
    input  logic de_i,
    output logic in_win_o,
    output logic centre_o,
    output logic frame_end_o
);
    localparam int unsigned CW = $clog2(H_ACT + 1);
    localparam int unsigned RW = $clog2(V_ACT + 1);
    localparam int unsigned X0 = (H_ACT - WIN) / 2;
    localparam int unsigned Y0 = (V_ACT - WIN) / 2;
    localparam int unsigned YC = Y0 + WIN / 2;

    typedef struct packed {
        logic [CW-1:0] col;
        logic [RW-1:0] row;
        logic          hs;
        logic          vs;
        logic          seen;
    } scan_t;

    scan_t scan_d, scan_q;
    logic  hs_rise, vs_rise;

    assign hs_rise = hsync_i && !scan_q.hs;
    assign vs_rise = vsync_i && !scan_q.vs;

    always_comb begin
        scan_d    = scan_q;
        scan_d.hs = hsync_i;
        scan_d.vs = vsync_i;
        if (vs_rise) begin
            scan_d.col  = '0;
            scan_d.row  = '0;
            scan_d.seen = 1'b0;
        end else if (hs_rise) begin
            scan_d.col  = '0;
            scan_d.seen = 1'b0;
            if (scan_q.seen && scan_q.row != RW'(V_ACT))
                scan_d.row = scan_q.row + 1'b1;
        end else if (de_i) begin
            scan_d.seen = 1'b1;
            if (scan_q.col != CW'(H_ACT))
                scan_d.col = scan_q.col + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) scan_q <= '0;
        else         scan_q <= scan_d;
    end

    assign in_win_o = de_i
                   && scan_q.col >= CW'(X0) && scan_q.col < CW'(X0 + WIN)
                   && scan_q.row >= RW'(Y0) && scan_q.row < RW'(Y0 + WIN);
    assign centre_o    = scan_q.row == RW'(YC);
    assign frame_end_o = vs_rise;

    AST_COL_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hs_rise |=> scan_q.col == '0); // R2
    AST_ROW_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vs_rise |=> (scan_q.row == '0 && !scan_q.seen)); // R2

endmodule

// File: rtl/fcw_colour.sv
module fcw_colour #(
    parameter logic [23:0] OUT_GREY = 24'h808080
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        de_i,
    input  logic        in_win_i,
    input  logic        pix_i,
    output logic [23:0] rgb_o,
    output logic        win_o
);
    import fcw_pkg::*;

    typedef struct packed {
        logic [23:0] rgb;
        logic        win;
    } col_t;

    col_t col_d, col_q;

    always_comb begin
        col_d.win = in_win_i;
        if (!de_i)         col_d.rgb = RGB_BLACK;
        else if (in_win_i) col_d.rgb = pix_i ? RGB_WHITE : RGB_BLACK;
        else               col_d.rgb = OUT_GREY;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) col_q <= '0;
        else         col_q <= col_d;
    end

    assign rgb_o = col_q.rgb;
    assign win_o = col_q.win;

    AST_WIN_NEEDS_DE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        col_q.win |-> $past(de_i)); // R3
    AST_WIN_BINARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        col_q.win |-> (col_q.rgb == RGB_BLACK || col_q.rgb == RGB_WHITE)); // R4

endmodule

// File: rtl/fcw_tally.sv
module fcw_tally #(
    parameter int unsigned WIN         = 250,
    parameter int unsigned MAX_FINGERS = 4,
    parameter logic [7:0]  CODE_BASE   = 8'hF0
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cnt_en_i,
    input  logic       frame_end_i,
    output logic [7:0] code_o,
    output logic       code_vld_o
);
    import fcw_pkg::*;

    localparam int unsigned BW = $clog2(WIN + 1);

    typedef struct packed {
        logic [BW-1:0] blk;
        logic [7:0]    code;
        logic          vld;
    } tally_t;

    tally_t tal_d, tal_q;

    always_comb begin
        tal_d     = tal_q;
        tal_d.vld = 1'b0;
        if (frame_end_i) begin
            tal_d.code = fcw_encode(32'(tal_q.blk), MAX_FINGERS, CODE_BASE);
            tal_d.vld  = 1'b1;
            tal_d.blk  = '0;
        end else if (cnt_en_i && tal_q.blk != BW'(WIN)) begin
            tal_d.blk = tal_q.blk + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            tal_q      <= '0;
            tal_q.code <= CODE_BASE;
        end else begin
            tal_q <= tal_d;
        end
    end

    assign code_o     = tal_q.code;
    assign code_vld_o = tal_q.vld;

    AST_VLD_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tal_q.vld |=> !tal_q.vld); // R8
    AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tal_q.vld |-> (tal_q.code >= CODE_BASE
                       && tal_q.code <= CODE_BASE + 8'(MAX_FINGERS))); // R7
    AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tal_q.vld |-> $stable(tal_q.code)); // R8
    AST_FRAME_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_end_i |=> tal_q.blk == '0); // R9

endmodule

// File: rtl/fcw_window_counter.sv
module fcw_window_counter #(
    parameter int unsigned H_ACT       = 800,
    parameter int unsigned V_ACT       = 600,
    parameter int unsigned WIN         = 250,
    parameter int unsigned MAX_FINGERS = 4,
    parameter logic [7:0]  CODE_BASE   = 8'hF0,
    parameter logic [23:0] OUT_GREY    = 24'h808080
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        hsync_i,
    input  logic        vsync_i,
    input  logic        de_i,
    input  logic        pix_i,
    output logic [23:0] rgb_o,
    output logic        win_o,
    output logic [7:0]  code_o,
    output logic        code_vld_o
);
    logic in_win, centre, frame_end, cnt_en;

    fcw_scan #(.H_ACT(H_ACT), .V_ACT(V_ACT), .WIN(WIN)) u_scan (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .hsync_i     (hsync_i),
        .vsync_i     (vsync_i),
        .de_i        (de_i),
        .in_win_o    (in_win),
        .centre_o    (centre),
        .frame_end_o (frame_end)
    );

    fcw_colour #(.OUT_GREY(OUT_GREY)) u_colour (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .de_i     (de_i),
        .in_win_i (in_win),
        .pix_i    (pix_i),
        .rgb_o    (rgb_o),
        .win_o    (win_o)
    );

    assign cnt_en = in_win && centre && !pix_i;

    fcw_tally #(.WIN(WIN), .MAX_FINGERS(MAX_FINGERS), .CODE_BASE(CODE_BASE)) u_tally (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .cnt_en_i    (cnt_en),
        .frame_end_i (frame_end),
        .code_o      (code_o),
        .code_vld_o  (code_vld_o)
    );

endmodule

// File: tb/fcw_window_counter_bench.sv
module fcw_window_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int H  = 40;
    localparam int V  = 30;
    localparam int W  = 20;
    localparam int X0 = (H - W) / 2;
    localparam int Y0 = (V - W) / 2;
    localparam int YC = Y0 + W / 2;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hs = 1'b0, vs = 1'b0, de = 1'b0, pix = 1'b1;
    logic [23:0] rgb;
    logic        win;
    logic [7:0]  code;
    logic        vld;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [7:0] last_code = 8'hF0;
    bit pat [V][H];

    fcw_window_counter #(.H_ACT(H), .V_ACT(V), .WIN(W)) u_fcw_window_counter (
        .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vsync_i(vs), .de_i(de),
        .pix_i(pix), .rgb_o(rgb), .win_o(win), .code_o(code), .code_vld_o(vld)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_code(input int blk);
        int f = blk / 2;
        return (f >= 1 && f <= 4) ? 8'(8'hF0 + f) : 8'hF0;
    endfunction

    // Drive one cycle at the falling edge, sample just after the rising edge.
    task automatic tick(input logic h, input logic v, input logic d, input logic p);
        @(negedge clk);
        hs = h; vs = v; de = d; pix = p;
        @(posedge clk);
        #1;
    endtask

    task automatic blank_cycle(input logic h, input logic v);
        tick(h, v, 1'b0, 1'b1);
        check("R5 blank rgb", rgb, 24'h0);
        check("R3 blank win", win, 0);
    endtask

    task automatic blank_line();
        for (int i = 0; i < 2; i++) blank_cycle(1'b1, 1'b0);
        for (int i = 0; i < 10; i++) blank_cycle(1'b0, 1'b0);
    endtask

    task automatic run_frame();
        int blk = 0;
        logic [7:0] ec;
        for (int c = X0; c < X0 + W; c++) if (!pat[YC][c]) blk++;
        ec = exp_code(blk);
        blank_line();
        blank_line();
        for (int r = 0; r < V; r++) begin
            for (int i = 0; i < 2; i++) blank_cycle(1'b1, 1'b0);
            for (int i = 0; i < 2; i++) blank_cycle(1'b0, 1'b0);
            for (int c = 0; c < H; c++) begin
                bit inw = (c >= X0 && c < X0 + W && r >= Y0 && r < Y0 + W);
                tick(1'b0, 1'b0, 1'b1, pat[r][c]);
                check("R3 window", win, inw);
                if (inw) check("R4 inside colour", rgb, pat[r][c] ? 24'hFFFFFF : 24'h0);
                else     check("R5 outside grey", rgb, 24'h808080);
                if (c != 0) check("R8 code held", code, last_code);
            end
            blank_cycle(1'b0, 1'b0);
        end
        blank_line();
        tick(1'b0, 1'b1, 1'b0, 1'b1);
        check("R8 strobe on frame sync", vld, 1);
        check("R7 code value", code, ec);
        last_code = ec;
        tick(1'b0, 1'b1, 1'b0, 1'b1);
        check("R8 strobe one cycle", vld, 0);
        tick(1'b0, 1'b0, 1'b0, 1'b1);
        check("R8 code held after strobe", code, ec);
    endtask

    task automatic fill(input bit noise);
        for (int r = 0; r < V; r++)
            for (int c = 0; c < H; c++)
                pat[r][c] = noise ? ($urandom % 4 != 0) : 1'b1;
        for (int c = X0; c < X0 + W; c++) pat[YC][c] = 1'b1;
    endtask

    task automatic place(input int n);
        for (int i = 0; i < n; i++) pat[YC][X0 + i] = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset rgb", rgb, 24'h0);
        check("R1 reset win", win, 0);
        check("R1 reset code", code, 8'hF0);
        check("R1 reset strobe", vld, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 released code", code, 8'hF0);
        check("R1 released strobe", vld, 0);

        // R9: empty frame
        fill(0); run_frame();
        // R7: one to four fingers, odd count rounds down
        for (int n = 2; n <= 8; n += 2) begin fill(0); place(n); run_frame(); end
        fill(0); place(3); run_frame();
        // R7: five fingers and one lone edge give no gesture
        fill(0); place(10); run_frame();
        fill(0); place(1); run_frame();
        // R6: edges outside window columns or off the centre row are ignored
        fill(0); place(4);
        for (int c = 0; c < X0; c++) pat[YC][c] = 1'b0;
        for (int c = X0 + W; c < H; c++) pat[YC][c] = 1'b0;
        for (int c = 0; c < H; c++) begin pat[YC-1][c] = 1'b0; pat[YC+1][c] = 1'b0; end
        run_frame();
        // R9: count restarts after a busy frame
        fill(0); place(W); run_frame();
        fill(0); run_frame();
        // R2 R3 R4 R5 R6 R7: random frames
        for (int k = 0; k < 28; k++) begin
            int m;
            fill(1);
            m = $urandom_range(0, 11);
            for (int i = 0; i < m; i++) pat[YC][X0 + ($urandom % W)] = 1'b0;
            run_frame();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule